// File: doc/BRIEF.md
# Multi-mode PWM timer counter

A 16-bit counter (width set by a parameter) that is advanced by a count-enable tick. A 4-bit mode input selects how it sequences. It can count up and wrap, or run up-and-down (dual slope). The mode also picks where TOP comes from: the full range, a fixed 8/9/10-bit limit, the active compare A value, or a capture register. It also picks the point where buffered compare writes become active and the point where the overflow flag is raised. Two compare channels produce one-cycle match strobes. The overflow flag is sticky until cleared.

Software writes compare A, compare B and the capture register over a shared data bus, one strobe per register. Compare writes always land in a buffer. In the immediate modes they also reach the active register in the same cycle. In the other modes the buffer is copied to the active register at the mode's commit point. The capture register is written directly.

Top module: `wave_timer`

## Requirements
- R1: After the active-low asynchronous reset, the count is 0, the direction output is 0 (up), the match strobes and the overflow flag are 0, and all registers hold 0.
- R2: The count and direction change only in a cycle where tick_i is 1; with tick_i at 0 they hold.
- R3: Mode 0 counts up through all ones and wraps to 0. On the tick taken at all ones the overflow flag sets. Compare writes become active in the same cycle.
- R4: Modes 5, 6 and 7 count up to a TOP of 255, 511 and 1023, and on the tick taken at TOP the count returns to 0. On that tick the buffers commit and the overflow flag sets.
- R5: Modes 1, 2 and 3 count 0 up to TOP (255, 511, 1023) and back down to 0, holding each of TOP and 0 for one tick. The direction output is 1 while counting down. The buffers commit on the tick taken at TOP. The overflow flag sets on the tick taken at 0 while counting down. If the count is at or above TOP while counting up, it reverses.
- R6: Modes 8 and 9 run dual slope with TOP from the capture register (8) or active compare A (9). Both the commit and the overflow flag occur on the tick taken at 0 while counting down.
- R7: Modes 10 and 11 run dual slope with TOP from the capture register (10) or active compare A (11). The commit occurs at TOP and the overflow flag sets at 0.
- R8: Modes 4 and 12 count up and return to 0 after TOP, taken from active compare A (4) or the capture register (12). Compare writes are immediate. The overflow flag sets only on the tick taken at all ones, which is reached when TOP is set below the count.
- R9: Modes 14 and 15 count up with TOP from the capture register (14) or active compare A (15) and return to 0 after TOP. The commit and the overflow flag occur on that tick.
- R10: In mode 13 the counter and direction hold on ticks. No match strobe, overflow set or commit occurs; compare writes only fill the buffers.
- R11: match_a_o (match_b_o) is 1 for exactly the cycle after a tick taken, outside mode 13, while the count equals active compare A (B).
- R12: The overflow flag stays 1 until a cycle with ovf_clr_i at 1 clears it. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for this cycle |
| mode_i | input | 4 | Waveform mode 0..15 |
| ocra_wr_i | input | 1 | Write compare A from wdata_i |
| ocrb_wr_i | input | 1 | Write compare B from wdata_i |
| icr_wr_i | input | 1 | Write capture register from wdata_i |
| wdata_i | input | W | Write data |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| cnt_o | output | W | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| match_a_o | output | 1 | Compare A match strobe |
| match_b_o | output | 1 | Compare B match strobe |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with W = 12, so the all-ones value is 4095. At that width the full-range wrap in mode 0 and the overflow at all ones in the compare-TOP modes take only a few thousand ticks. The fixed 10-bit TOP of modes 3 and 7 still fits below that value. Modes are exercised in turn under random ticks, writes and clears. One directed sequence moves TOP below the running count so the count has to pass through all ones.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {ST_UP, ST_DUAL, ST_HOLD} style_e;
  typedef enum logic [1:0] {TS_MAX, TS_FIX, TS_OCRA, TS_ICR} topsrc_e;
  typedef enum logic [1:0] {PT_IMM, PT_TOP, PT_BOT, PT_NONE} upd_e;
  typedef enum logic [1:0] {OV_MAX, OV_TOP, OV_BOT, OV_NONE} ovp_e;

  typedef struct packed {
    style_e     style;
    topsrc_e    src;
    logic [1:0] fix;   // 0:8-bit 1:9-bit 2:10-bit
    upd_e       upd;
    ovp_e       ovp;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c = '{style: ST_UP, src: TS_MAX, fix: 2'd0, upd: PT_IMM, ovp: OV_MAX};
    case (m)
      4'd0:  c = '{ST_UP,   TS_MAX,  2'd0, PT_IMM,  OV_MAX};
      4'd1:  c = '{ST_DUAL, TS_FIX,  2'd0, PT_TOP,  OV_BOT};
      4'd2:  c = '{ST_DUAL, TS_FIX,  2'd1, PT_TOP,  OV_BOT};
      4'd3:  c = '{ST_DUAL, TS_FIX,  2'd2, PT_TOP,  OV_BOT};
      4'd4:  c = '{ST_UP,   TS_OCRA, 2'd0, PT_IMM,  OV_MAX};
      4'd5:  c = '{ST_UP,   TS_FIX,  2'd0, PT_BOT,  OV_TOP};
      4'd6:  c = '{ST_UP,   TS_FIX,  2'd1, PT_BOT,  OV_TOP};
      4'd7:  c = '{ST_UP,   TS_FIX,  2'd2, PT_BOT,  OV_TOP};
      4'd8:  c = '{ST_DUAL, TS_ICR,  2'd0, PT_BOT,  OV_BOT};
      4'd9:  c = '{ST_DUAL, TS_OCRA, 2'd0, PT_BOT,  OV_BOT};
      4'd10: c = '{ST_DUAL, TS_ICR,  2'd0, PT_TOP,  OV_BOT};
      4'd11: c = '{ST_DUAL, TS_OCRA, 2'd0, PT_TOP,  OV_BOT};
      4'd12: c = '{ST_UP,   TS_ICR,  2'd0, PT_IMM,  OV_MAX};
      4'd13: c = '{ST_HOLD, TS_MAX,  2'd0, PT_NONE, OV_NONE};
      4'd14: c = '{ST_UP,   TS_ICR,  2'd0, PT_BOT,  OV_TOP};
      default: c = '{ST_UP, TS_OCRA, 2'd0, PT_BOT,  OV_TOP};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/wt_mode_dec.sv
module wt_mode_dec
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] ocra_i,
  input  logic [W-1:0] icr_i,
  output mode_cfg_t    cfg_o,
  output logic [W-1:0] top_o
);
  localparam logic [W-1:0] TOP8  = W'(255);
  localparam logic [W-1:0] TOP9  = W'(511);
  localparam logic [W-1:0] TOP10 = W'(1023);

  always_comb begin
    cfg_o = decode_mode(mode_i);
    case (cfg_o.src)
      TS_FIX:  top_o = (cfg_o.fix == 2'd0) ? TOP8 : (cfg_o.fix == 2'd1) ? TOP9 : TOP10;
      TS_OCRA: top_o = ocra_i;
      TS_ICR:  top_o = icr_i;
      default: top_o = '1;
    endcase
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  style_e       style_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         ev_top_o,
  output logic         ev_bot_o,
  output logic         ev_max_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         ev_top, ev_bot;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ev_top = 1'b0;
    ev_bot = 1'b0;
    case (style_i)
      ST_UP: begin
        down_d = 1'b0;
        if (cnt_q == top_i) begin
          cnt_d  = '0;
          ev_top = 1'b1;
          ev_bot = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_DUAL: begin
        if (!down_q) begin
          if (cnt_q >= top_i) begin  // reverse, also when TOP fell below count
            ev_top = 1'b1;
            cnt_d  = (cnt_q == '0) ? '0 : cnt_q - ONE;
            down_d = (cnt_q != '0);
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else if (cnt_q == '0) begin
          ev_bot = 1'b1;
          cnt_d  = ONE;
          down_d = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign down_o   = down_q;
  assign ev_top_o = tick_i && ev_top;
  assign ev_bot_o = tick_i && ev_bot;
  assign ev_max_o = tick_i && (style_i != ST_HOLD) && (cnt_q == '1);
endmodule

// File: rtl/wt_cmp_buf.sv
module wt_cmp_buf #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         imm_i,
  input  logic         commit_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (imm_i)         act_q <= wr_i ? wdata_i : buf_q;
      else if (commit_i) act_q <= buf_q;  // same-cycle write waits for next commit
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [3:0]   mode_i,
  input  logic         ocra_wr_i,
  input  logic         ocrb_wr_i,
  input  logic         icr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_down_o,
  output logic         match_a_o,
  output logic         match_b_o,
  output logic         ovf_o
);
  localparam int NCH = 2;

  mode_cfg_t    cfg;
  logic [W-1:0] top, icr_q, cnt;
  logic [W-1:0] act [NCH];
  logic         ev_top, ev_bot, ev_max;
  logic         imm, commit, ovf_set, ovf_q;
  logic [NCH-1:0] wr, match_q;

  assign wr = {ocrb_wr_i, ocra_wr_i};

  wt_mode_dec #(.W(W)) u_dec (
    .mode_i (mode_i),
    .ocra_i (act[0]),
    .icr_i  (icr_q),
    .cfg_o  (cfg),
    .top_o  (top)
  );

  wt_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .style_i  (cfg.style),
    .top_i    (top),
    .cnt_o    (cnt),
    .down_o   (dir_down_o),
    .ev_top_o (ev_top),
    .ev_bot_o (ev_bot),
    .ev_max_o (ev_max)
  );

  assign imm    = (cfg.upd == PT_IMM);
  assign commit = ((cfg.upd == PT_TOP) && ev_top) || ((cfg.upd == PT_BOT) && ev_bot);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wt_cmp_buf #(.W(W)) u_buf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr[i]),
      .wdata_i  (wdata_i),
      .imm_i    (imm),
      .commit_i (commit),
      .act_o    (act[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q[i] <= 1'b0;
      else         match_q[i] <= tick_i && (cfg.style != ST_HOLD) && (cnt == act[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       icr_q <= '0;
    else if (icr_wr_i) icr_q <= wdata_i;
  end

  assign ovf_set = ((cfg.ovp == OV_MAX) && ev_max) ||
                   ((cfg.ovp == OV_TOP) && ev_top) ||
                   ((cfg.ovp == OV_BOT) && ev_bot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set)   ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o     = cnt;
  assign match_a_o = match_q[0];
  assign match_b_o = match_q[1];
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic [3:0]   mode_i,
  input logic         ovf_clr_i,
  input logic [W-1:0] cnt_o,
  input logic         dir_down_o,
  input logic         match_a_o,
  input logic         match_b_o,
  input logic         ovf_o
);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (cnt_o == $past(cnt_o)) && (dir_down_o == $past(dir_down_o)));

  // R10
  rsv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 4'd13) |=> (cnt_o == $past(cnt_o)));

  // R10
  rsv_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd13) |=> (!match_a_o && !match_b_o));

  // R11
  match_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_a_o || match_b_o) |-> $past(tick_i));

  // R12
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(tick_i));

  // R12
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && (!tick_i || mode_i == 4'd13)) |=> !ovf_o);

  // R5
  dir_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_down_o) |-> $past(tick_i));

  // R4
  fast_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 4'd5 && cnt_o == W'(255)) |=> (cnt_o == '0));
endmodule

bind wave_timer wave_timer_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .mode_i     (mode_i),
  .ovf_clr_i  (ovf_clr_i),
  .cnt_o      (cnt_o),
  .dir_down_o (dir_down_o),
  .match_a_o  (match_a_o),
  .match_b_o  (match_b_o),
  .ovf_o      (ovf_o)
);

// File: tb/wave_timer_test.sv
module wave_timer_test;
  localparam int W    = 12;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         tick = 0, ocra_wr = 0, ocrb_wr = 0, icr_wr = 0, ovf_clr = 0;
  logic [3:0]   mode = 4'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt;
  logic         dir, ma, mb, ovf;

  wave_timer #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode),
    .ocra_wr_i(ocra_wr), .ocrb_wr_i(ocrb_wr), .icr_wr_i(icr_wr),
    .wdata_i(wdata), .ovf_clr_i(ovf_clr),
    .cnt_o(cnt), .dir_down_o(dir), .match_a_o(ma), .match_b_o(mb), .ovf_o(ovf)
  );

  int    tests = 0, fails = 0;
  string req = "R1";
  bit    done = 0;

  // reference model state
  int m_cnt = 0, m_down = 0, m_bufa = 0, m_bufb = 0, m_acta = 0, m_actb = 0;
  int m_icr = 0, m_ovf = 0, m_ma = 0, m_mb = 0;
  int md, top, upd, ovp, c, nc, nd;
  bit hold, dual, et, eb, em, set, com;

  // upd: 0 immediate, 1 at TOP, 2 at BOTTOM, 3 never; ovp: 0 MAX, 1 TOP, 2 BOTTOM, 3 never
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0;
      m_icr = 0; m_ovf = 0; m_ma = 0; m_mb = 0;
    end else begin
      md = int'(mode); hold = 0; dual = 0;
      case (md)
        0:        begin top = MAXV;   upd = 0; ovp = 0; end
        1, 2, 3:  begin top = (256 << (md - 1)) - 1; dual = 1; upd = 1; ovp = 2; end
        4:        begin top = m_acta; upd = 0; ovp = 0; end
        5, 6, 7:  begin top = (256 << (md - 5)) - 1; upd = 2; ovp = 1; end
        8:        begin top = m_icr;  dual = 1; upd = 2; ovp = 2; end
        9:        begin top = m_acta; dual = 1; upd = 2; ovp = 2; end
        10:       begin top = m_icr;  dual = 1; upd = 1; ovp = 2; end
        11:       begin top = m_acta; dual = 1; upd = 1; ovp = 2; end
        12:       begin top = m_icr;  upd = 0; ovp = 0; end
        13:       begin top = 0; hold = 1; upd = 3; ovp = 3; end
        14:       begin top = m_icr;  upd = 2; ovp = 1; end
        default:  begin top = m_acta; upd = 2; ovp = 1; end
      endcase
      c = m_cnt; nc = c; nd = m_down; et = 0; eb = 0; em = 0;
      if (tick && !hold) begin
        em = (c == MAXV);
        if (!dual) begin
          nd = 0;
          if (c == top) begin nc = 0; et = 1; eb = 1; end
          else nc = (c + 1) & MAXV;
        end else if (m_down == 0) begin
          if (c >= top) begin et = 1; nc = (c == 0) ? 0 : c - 1; nd = (c != 0); end
          else nc = c + 1;
        end else begin
          if (c == 0) begin eb = 1; nc = 1; nd = 0; end
          else nc = c - 1;
        end
      end
      m_ma = (tick && !hold && c == m_acta);
      m_mb = (tick && !hold && c == m_actb);
      set = (ovp == 0 && em) || (ovp == 1 && et) || (ovp == 2 && eb);
      if (set) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      com = (upd == 1 && et) || (upd == 2 && eb);
      if (upd == 0) begin
        m_acta = ocra_wr ? int'(wdata) : m_bufa;
        m_actb = ocrb_wr ? int'(wdata) : m_bufb;
      end else if (com) begin
        m_acta = m_bufa;
        m_actb = m_bufb;
      end
      if (ocra_wr) m_bufa = int'(wdata);
      if (ocrb_wr) m_bufb = int'(wdata);
      if (icr_wr)  m_icr  = int'(wdata);
      m_cnt = nc; m_down = nd;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (int'(cnt) != m_cnt || int'(dir) != m_down || int'(ma) != m_ma ||
          int'(mb) != m_mb || int'(ovf) != m_ovf) begin
        fails++;
        $display("FAIL %s mode=%0d cnt=%0d/%0d dir=%0d/%0d ma=%0d/%0d mb=%0d/%0d ovf=%0d/%0d (actual/expected)",
                 req, mode, cnt, m_cnt, dir, m_down, ma, m_ma, mb, m_mb, ovf, m_ovf);
      end
    end
  end

  task automatic write(input int sel, input int val);
    @(negedge clk);
    tick = 0; ovf_clr = 0;
    ocra_wr = (sel == 0); ocrb_wr = (sel == 1); icr_wr = (sel == 2);
    wdata = W'(val);
    @(negedge clk);
    ocra_wr = 0; ocrb_wr = 0; icr_wr = 0;
  endtask

  task automatic run(input int n, input int tp, input int wp, input int cp, input int wmax);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick    = ($urandom_range(99) < tp);
      ovf_clr = ($urandom_range(99) < cp);
      ocra_wr = 0; ocrb_wr = 0; icr_wr = 0;
      if ($urandom_range(99) < wp) begin
        case ($urandom_range(2))
          0: ocra_wr = 1;
          1: ocrb_wr = 1;
          default: icr_wr = 1;
        endcase
        wdata = W'($urandom_range(wmax));
      end
    end
    @(negedge clk);
    tick = 0; ovf_clr = 0; ocra_wr = 0; ocrb_wr = 0; icr_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog %s: run did not finish (actual hung, expected done)", req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    req = "R2"; mode = 4'd5;
    write(1, 40);
    run(30, 0, 5, 0, 300);
    run(600, 70, 1, 1, 300);

    req = "R3"; mode = 4'd0;
    write(1, 100);
    run(9000, 100, 0, 1, 10);
    run(600, 60, 3, 2, 4000);

    req = "R4";
    for (int m = 5; m <= 7; m++) begin
      mode = 4'(m);
      write(0, 120); write(1, 30);
      run(3000, 90, 2, 1, 1023);
    end

    req = "R5";
    for (int m = 1; m <= 3; m++) begin
      mode = 4'(m);
      write(0, 200); write(1, 7);
      run(3500, 90, 2, 1, 1023);
    end

    req = "R6";
    write(2, 90); write(0, 70); write(1, 20);
    mode = 4'd8;  run(1500, 85, 2, 2, 120);
    write(0, 70);
    mode = 4'd9;  run(1500, 85, 2, 2, 120);

    req = "R7";
    write(2, 80); write(0, 60);
    mode = 4'd10; run(1500, 85, 2, 2, 120);
    write(0, 60);
    mode = 4'd11; run(1500, 85, 2, 2, 120);

    req = "R8";
    mode = 4'd4;  write(0, 50); run(1200, 85, 2, 2, 100);
    write(2, 70);
    mode = 4'd12; run(1200, 85, 2, 2, 100);
    mode = 4'd4;  write(0, 600); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    while (int'(cnt) < 500) run(1, 100, 0, 0, 1);
    write(0, 100);
    run(4200, 100, 0, 0, 1);
    run(200, 80, 0, 20, 1);

    req = "R9";
    write(2, 150); write(0, 90);
    mode = 4'd14; run(1500, 85, 2, 2, 200);
    write(0, 90);
    mode = 4'd15; run(1500, 85, 2, 2, 200);

    req = "R10";
    mode = 4'd13; run(800, 80, 5, 3, 200);
    mode = 4'd7;  run(600, 90, 2, 2, 200);

    req = "R11";
    write(0, 200); write(1, 50);
    mode = 4'd15; run(2000, 75, 1, 0, 250);

    req = "R12";
    mode = 4'd5; write(0, 0);
    run(3000, 100, 0, 30, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule